// File: doc/BRIEF.md
# Timer-Clocked Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. Each character is ten bits on the line: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The port has no baud generator of its own. It takes the overflow pulses of a separate 8-bit auto-reload timer and divides them down. Each bit is 32 overflows long, or 16 overflows when the rate-doubling bit is set.

Software reaches the port through three byte-wide registers chosen by `reg_sel`. The data register is really two registers. A write loads the transmit shifter and starts a frame, and a read returns the last received byte. The control register holds these fields:
- a two-bit mode field;
- the receive enable;
- the captured stop bit;
- a transmit-done flag, raised when the stop bit begins on the line;
- a receive-done flag, raised in the middle of the received stop bit.

Neither flag clears itself; software writes it back to 0. The power register holds the rate-doubling bit.

Top module: `tmr_uart`

## Requirements
- R1: After reset, `txd` is 1, and the data, control and power registers all read 0x00.
- R2: Each bit on the line lasts 32 `tmr_ovf` pulses when the doubling bit (power register bit 7) is 0, and 16 pulses when it is 1. The receiver also times its sampling in these units.
- R3: A data write (`reg_sel`=0) while the transmitter is idle sends one frame on `txd`: a 0 start bit, the eight bits LSB first, then a 1 stop bit. `txd` rests at 1 between frames.
- R4: A data write made while a frame is being sent is dropped. The frame in flight ends normally and no second frame follows.
- R5: The transmit-done flag (control bit 1) goes to 1 on the same edge where `txd` enters the stop bit, which is exactly nine bit times after the start bit began.
- R6: While reception is on, a falling edge on `rxd` starts a frame. Each bit is sampled at its middle. The byte goes to the receive buffer and the receive-done flag (control bit 0) rises in the middle of the stop bit, 9.5 bit times after the edge.
- R7: The stop-bit value sampled by the receiver is stored in control bit 2. It is stored whether the value is 1 or 0, and the byte is still delivered.
- R8: A start bit that reads 1 at its middle is discarded. No flag is set and the buffer is unchanged, and the next proper frame is received correctly.
- R9: With the receive enable (control bit 4) at 0, `rxd` has no effect. Clearing the enable during a frame abandons that frame.
- R10: A data read returns the receive buffer. A data write never changes what a data read returns.
- R11: Both done flags stay at 1 until software writes the control register with that bit at 0. When a hardware set and a software clear fall on the same edge, the set wins.
- R12: A frame that completes while the receive-done flag is still 1 overwrites the receive buffer, and the flag stays 1.
- R13: A control write stores bits 7:6 (mode), 4, 2, 1 and 0. Bits 5 and 3 read as 0. The power register keeps only bit 7. Selector value 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_ovf | input | 1 | One-cycle overflow pulse from the external reload timer |
| reg_sel | input | 2 | Register select: 0 data, 1 control, 2 power |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The transmitter setting its done flag can fall on the same edge as software writing the control register to clear that flag. The bench provokes this with the doubling bit at 1, where every sub-tick is an overflow cycle. During a whole frame it writes a clear on every overflow cycle and reads the flag straight after each of those writes. Exactly one of those reads, the one at the start of the stop bit, must show the flag at 1. Seeing none means the clear overrode the set.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int REG_W = 8;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_PWR  = 2'd2;

  localparam int CB_MODE_HI = 7;
  localparam int CB_MODE_LO = 6;
  localparam int CB_REN     = 4;
  localparam int CB_STOP    = 2;
  localparam int CB_TDONE   = 1;
  localparam int CB_RDONE   = 0;
  localparam int PB_DBL     = 7;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_st_e;
endpackage

// File: rtl/sp_baud.sv
module sp_baud (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic dbl,
  output logic sub_tick
);
  logic half_q, half_d;

  always_comb begin
    half_d = half_q;
    if (ovf) half_d = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  // 16 sub-ticks per bit: every overflow when doubled, every second otherwise
  assign sub_tick = ovf & (dbl | half_q);
endmodule

// File: rtl/sp_tx.sv
module sp_tx #(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sub_tick,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          txd,
  output logic          busy,
  output logic          stop_start
);
  localparam int CW = $clog2(OS);
  localparam int IW = $clog2(DW + 2);
  localparam logic [CW-1:0] CNT_LAST = CW'(OS - 1);
  localparam logic [IW-1:0] IDX_LAST_D = IW'(DW);
  localparam logic [IW-1:0] IDX_STOP = IW'(DW + 1);

  logic          pend_q, pend_d;
  logic          act_q, act_d;
  logic          txd_q, txd_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;

  always_comb begin
    pend_d     = pend_q;
    act_d      = act_q;
    txd_d      = txd_q;
    idx_d      = idx_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    stop_start = 1'b0;
    if (pend_q) begin
      if (sub_tick) begin
        pend_d = 1'b0;
        act_d  = 1'b1;
        idx_d  = '0;
        cnt_d  = '0;
        txd_d  = 1'b0;
      end
    end else if (act_q) begin
      if (sub_tick) begin
        if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          if (idx_q == IDX_STOP) begin
            act_d = 1'b0;
          end else begin
            idx_d = idx_q + 1'b1;
            if (idx_q == IDX_LAST_D) begin
              txd_d      = 1'b1;
              stop_start = 1'b1;
            end else begin
              txd_d = sh_q[0];
              sh_d  = sh_q >> 1;
            end
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (load) begin
      pend_d = 1'b1;
      sh_d   = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      txd_q  <= 1'b1;
      idx_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      txd_q  <= txd_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
    end
  end

  assign txd  = txd_q;
  assign busy = pend_q | act_q;
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sub_tick,
  input  logic          en,
  input  logic          rxd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          stop_bit,
  output logic          busy
);
  localparam int CW = $clog2(OS);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(OS - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(OS / 2 - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(DW - 1);

  logic          s1_q, s2_q, s3_q;
  rx_st_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] sh_q, sh_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    done  = 1'b0;
    if (!en) begin
      st_d = RX_IDLE;
    end else begin
      case (st_q)
        RX_IDLE: begin
          if (s3_q && !s2_q) begin
            st_d  = RX_START;
            cnt_d = '0;
          end
        end
        RX_START: begin
          if (sub_tick) begin
            if (cnt_q == CNT_MID) begin
              cnt_d = '0;
              idx_d = '0;
              st_d  = s2_q ? RX_IDLE : RX_DATA;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (sub_tick) begin
            if (cnt_q == CNT_LAST) begin
              cnt_d = '0;
              sh_d  = {s2_q, sh_q[DW-1:1]};
              if (idx_q == IDX_LAST) st_d = RX_STOP;
              else                   idx_d = idx_q + 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (sub_tick) begin
            if (cnt_q == CNT_LAST) begin
              done = 1'b1;
              st_d = RX_IDLE;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
    end
  end

  assign data     = sh_q;
  assign stop_bit = s2_q;
  assign busy     = (st_q != RX_IDLE);
endmodule

// File: rtl/tmr_uart.sv
module tmr_uart
  import sp_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_ovf,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             rxd,
  output logic             txd
);
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  logic rst_ni;
  assign rst_ni = rst_sync_q;

  logic             data_wr, ctrl_wr, pwr_wr;
  logic             sub_tick;
  logic             tx_busy, tx_stop;
  logic             rx_done, rx_stop, rx_busy;
  logic [REG_W-1:0] rx_data;

  logic [1:0]       mode_q, mode_d;
  logic             ren_q, ren_d;
  logic             rb8_q, rb8_d;
  logic             ti_q, ti_d;
  logic             ri_q, ri_d;
  logic             dbl_q, dbl_d;
  logic [REG_W-1:0] rbuf_q, rbuf_d;

  assign data_wr = wr_en && (reg_sel == SEL_DATA);
  assign ctrl_wr = wr_en && (reg_sel == SEL_CTRL);
  assign pwr_wr  = wr_en && (reg_sel == SEL_PWR);

  sp_baud u_baud (
    .clk      (clk),
    .rst_n    (rst_ni),
    .ovf      (tmr_ovf),
    .dbl      (dbl_q),
    .sub_tick (sub_tick)
  );

  sp_tx #(.DW(REG_W), .OS(OS)) u_tx (
    .clk        (clk),
    .rst_n      (rst_ni),
    .sub_tick   (sub_tick),
    .load       (data_wr),
    .din        (wdata),
    .txd        (txd),
    .busy       (tx_busy),
    .stop_start (tx_stop)
  );

  sp_rx #(.DW(REG_W), .OS(OS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_ni),
    .sub_tick (sub_tick),
    .en       (ren_q),
    .rxd      (rxd),
    .done     (rx_done),
    .data     (rx_data),
    .stop_bit (rx_stop),
    .busy     (rx_busy)
  );

  always_comb begin
    mode_d = mode_q;
    ren_d  = ren_q;
    rb8_d  = rb8_q;
    ti_d   = ti_q;
    ri_d   = ri_q;
    dbl_d  = dbl_q;
    rbuf_d = rbuf_q;
    if (ctrl_wr) begin
      mode_d = wdata[CB_MODE_HI:CB_MODE_LO];
      ren_d  = wdata[CB_REN];
      rb8_d  = wdata[CB_STOP];
      ti_d   = wdata[CB_TDONE];
      ri_d   = wdata[CB_RDONE];
    end
    if (pwr_wr) dbl_d = wdata[PB_DBL];
    // hardware events take priority over a same-cycle software write
    if (tx_stop) ti_d = 1'b1;
    if (rx_done) begin
      rbuf_d = rx_data;
      rb8_d  = rx_stop;
      ri_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ren_q  <= 1'b0;
      rb8_q  <= 1'b0;
      ti_q   <= 1'b0;
      ri_q   <= 1'b0;
      dbl_q  <= 1'b0;
      rbuf_q <= '0;
    end else begin
      mode_q <= mode_d;
      ren_q  <= ren_d;
      rb8_q  <= rb8_d;
      ti_q   <= ti_d;
      ri_q   <= ri_d;
      dbl_q  <= dbl_d;
      rbuf_q <= rbuf_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_sel)
      SEL_DATA: rdata = rbuf_q;
      SEL_CTRL: begin
        rdata[CB_MODE_HI:CB_MODE_LO] = mode_q;
        rdata[CB_REN]   = ren_q;
        rdata[CB_STOP]  = rb8_q;
        rdata[CB_TDONE] = ti_q;
        rdata[CB_RDONE] = ri_q;
      end
      SEL_PWR: rdata[PB_DBL] = dbl_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/sp_chk.sv
module sp_chk (
  input logic clk,
  input logic rst_n,
  input logic tmr_ovf,
  input logic sub_tick,
  input logic txd,
  input logic tx_busy,
  input logic ti,
  input logic ri,
  input logic ren,
  input logic rx_busy,
  input logic ctrl_wr
);
  // R2
  sub_tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_tick |-> tmr_ovf);

  // R3
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R5
  ti_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ti) && !$past(ctrl_wr)) |-> (txd && tx_busy));

  // R11
  ti_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !ctrl_wr) |=> ti);

  // R11
  ri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !ctrl_wr) |=> ri);

  // R9
  ren_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> !rx_busy);
endmodule

bind tmr_uart sp_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_ni),
  .tmr_ovf  (tmr_ovf),
  .sub_tick (sub_tick),
  .txd      (txd),
  .tx_busy  (tx_busy),
  .ti       (ti_q),
  .ri       (ri_q),
  .ren      (ren_q),
  .rx_busy  (rx_busy),
  .ctrl_wr  (ctrl_wr)
);

// File: tb/tb_tmr_uart.sv
module tb_tmr_uart;
  localparam int CLK_P = 10;
  localparam int OVP   = 3;
  localparam int WDOG  = 150000;
  localparam logic [1:0] S_DATA = 2'd0;
  localparam logic [1:0] S_CTRL = 2'd1;
  localparam logic [1:0] S_PWR  = 2'd2;

  logic       clk, rst_n, wr_en, rxd;
  logic [1:0] reg_sel;
  logic [7:0] wdata, rdata;
  logic       txd, tmr_ovf;
  int         cyc;
  int         n_chk, n_err;
  bit         dbl_b;
  logic [7:0] last_rx;

  assign tmr_ovf = (cyc % OVP) == (OVP - 1);

  tmr_uart dut (
    .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .reg_sel(reg_sel),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int bitc();
    return OVP * (dbl_b ? 16 : 32);
  endfunction

  function automatic logic [7:0] ectrl(bit ren, bit stp, bit td, bit rd_f);
    return {2'b01, 1'b0, ren, 1'b0, stp, td, rd_f};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    reg_sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] v);
    reg_sel = s;
    #1;
    v = rdata;
  endtask

  task automatic tx_frame(logic [7:0] b, bit extra);
    logic [7:0] v, got;
    bit ok_frame, ti0, ti1, low_after;
    int t0, rel, bc, k;
    bc = bitc();
    wr(S_CTRL, 8'h50);
    wr(S_DATA, b);
    rd(S_DATA, v);
    chk(v == last_rx, "R10 data read after write", v, last_rx);
    t0 = -1;
    for (int i = 0; i < 3 * bc; i++) begin
      if (txd == 1'b0) begin t0 = cyc; break; end
      @(negedge clk);
    end
    ok_frame = (t0 >= 0); got = '0; ti0 = 1'b1; ti1 = 1'b0; low_after = 1'b0;
    while (t0 >= 0 && (cyc - t0) < 12 * bc) begin
      rel = cyc - t0;
      if ((rel % bc) == bc / 2 && rel / bc < 10) begin
        k = rel / bc;
        if (k == 0 && txd != 1'b0) ok_frame = 1'b0;
        else if (k >= 1 && k <= 8) got[k-1] = txd;
        else if (k == 9 && txd != 1'b1) ok_frame = 1'b0;
      end
      if (rel == 9 * bc - 1) begin rd(S_CTRL, v); ti0 = v[1]; end
      if (rel == 9 * bc)     begin rd(S_CTRL, v); ti1 = v[1]; end
      if (rel >= 10 * bc + 2 && txd == 1'b0) low_after = 1'b1;
      if (extra && rel == 3 * bc + 5) begin
        reg_sel = S_DATA; wdata = ~b; wr_en = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    // R2 R3: bits sampled at mid-bit using the bit length computed from the doubling bit
    chk(ok_frame && got == b, dbl_b ? "R2 R3 frame (doubled)" : "R2 R3 frame", got, b);
    chk(!ti0 && ti1, "R5 transmit-done at stop start", {ti0, ti1}, 2'b01);
    if (extra) chk(!low_after, "R4 write during frame dropped", low_after, 0);
  endtask

  task automatic rx_drive(logic [7:0] b, bit stp, bit glitch);
    int bc;
    bc = bitc();
    if (glitch) begin
      rxd = 1'b0; repeat (bc / 4) @(negedge clk);
      rxd = 1'b1;
    end else begin
      rxd = 1'b0; repeat (bc) @(negedge clk);
      for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (bc) @(negedge clk); end
      rxd = stp; repeat (bc) @(negedge clk);
      rxd = 1'b1;
    end
  endtask

  // mode: 0 = no reception expected, 1 = reception with timing, 2 = reception, flag already set
  task automatic rx_frame(logic [7:0] b, bit stp, bit glitch, int mode);
    logic [7:0] v;
    int s, first, bc, sub;
    bc = bitc(); sub = bc / 16; s = cyc; first = -1;
    fork
      rx_drive(b, stp, glitch);
      begin
        for (int i = 0; i < 11 * bc; i++) begin
          rd(S_CTRL, v);
          if (v[0] && first < 0) first = cyc;
          @(negedge clk);
        end
      end
    join
    if (mode == 0) begin
      chk(first < 0, "R8 R9 no receive-done", first, -1);
      rd(S_DATA, v);
      chk(v == last_rx, "R8 R9 buffer unchanged", v, last_rx);
    end else begin
      if (mode == 1)
        chk(first >= s + 151 * sub && first <= s + 152 * sub + 4,
            "R6 receive-done at mid stop", first - s, 152 * sub);
      rd(S_DATA, v);
      chk(v == b, "R6 R12 received byte", v, b);
      rd(S_CTRL, v);
      chk(v[2] == stp && v[0], "R7 stop bit captured", v, {5'b0, stp, 2'b01});
      last_rx = b;
    end
  endtask

  logic [7:0] rv;
  int hits, prevw, dummy;

  initial begin
    dummy = $urandom(32'h5A17);
    cyc = 0; n_chk = 0; n_err = 0; dbl_b = 1'b0; last_rx = 8'h00;
    rst_n = 1'b0; wr_en = 1'b0; reg_sel = S_DATA; wdata = '0; rxd = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    rd(S_DATA, rv); chk(rv == 8'h00, "R1 data reset", rv, 0);
    rd(S_CTRL, rv); chk(rv == 8'h00, "R1 control reset", rv, 0);
    rd(S_PWR, rv);  chk(rv == 8'h00, "R1 power reset", rv, 0);

    // R13 field layout
    wr(S_CTRL, 8'hFF); rd(S_CTRL, rv); chk(rv == 8'hD7, "R13 control fields", rv, 8'hD7);
    wr(S_PWR, 8'hFF);  rd(S_PWR, rv);  chk(rv == 8'h80, "R13 power field", rv, 8'h80);
    rd(2'd3, rv); chk(rv == 8'h00, "R13 unused select", rv, 0);
    wr(S_PWR, 8'h00);
    wr(S_CTRL, 8'h50); rd(S_CTRL, rv); chk(rv == ectrl(1, 0, 0, 0), "R13 mode readback", rv, 8'h50);

    // transmit: directed corners then random
    tx_frame(8'h00, 1'b0);
    tx_frame(8'hFF, 1'b0);
    tx_frame(8'h81, 1'b1);
    for (int i = 0; i < 3; i++) tx_frame(8'($urandom), 1'b0);

    // receive
    for (int i = 0; i < 4; i++) begin
      wr(S_CTRL, 8'h50);
      rx_frame(8'($urandom), 1'b1, 1'b0, 1);
    end
    wr(S_CTRL, 8'h50);
    rx_frame(8'h3C, 1'b0, 1'b0, 1);            // R7 stop bit low

    // R8 false start then a good frame
    wr(S_CTRL, 8'h50);
    rx_frame(8'h00, 1'b1, 1'b1, 0);
    rx_frame(8'hA6, 1'b1, 1'b0, 1);

    // R12 overrun and R11 flag persistence
    rx_frame(8'h5D, 1'b1, 1'b0, 2);
    repeat (3 * bitc()) @(negedge clk);
    rd(S_CTRL, rv); chk(rv[0] == 1'b1, "R11 receive-done persists", rv[0], 1);
    wr(S_CTRL, 8'h50); rd(S_CTRL, rv); chk(rv[0] == 1'b0, "R11 receive-done cleared", rv[0], 0);

    // R9 reception disabled, then disabled mid-frame
    wr(S_CTRL, 8'h40);
    rx_frame(8'h99, 1'b1, 1'b0, 0);
    wr(S_CTRL, 8'h50);
    fork
      rx_frame(8'h66, 1'b1, 1'b0, 0);
      begin repeat (4 * bitc()) @(negedge clk); wr(S_CTRL, 8'h40); end
    join
    wr(S_CTRL, 8'h50);
    rx_frame(8'hC3, 1'b1, 1'b0, 1);

    // doubled rate
    wr(S_PWR, 8'h80); dbl_b = 1'b1;
    tx_frame(8'h2B, 1'b0);
    tx_frame(8'($urandom), 1'b0);
    wr(S_CTRL, 8'h50);
    rx_frame(8'hE4, 1'b1, 1'b0, 1);

    // R11 transmit-done set and software clear on the same edge
    wr(S_CTRL, 8'h50);
    wr(S_DATA, 8'h47);
    hits = 0; prevw = 0;
    for (int i = 0; i < 12 * bitc(); i++) begin
      @(negedge clk);
      reg_sel = S_CTRL;
      #1;
      if (prevw != 0 && rdata[1]) hits++;
      prevw = tmr_ovf ? 1 : 0;
      wr_en = tmr_ovf; wdata = 8'h50;
    end
    @(negedge clk); wr_en = 1'b0;
    chk(hits == 1, "R11 set wins over same-edge clear", hits, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= WDOG);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WDOG);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule